// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a load/store pipeline. It accepts one request per clock. Each request carries an addressing form, an operand size and a displacement field. The block also receives three 32-bit operands: a general register value, the index register value (R0) and a global base register value.

There are four addressing forms. Two pair the general register with either a short displacement or the index register. The other two pair the global base register with either a long displacement or the index register. A displacement is always zero-extended before use. It is then scaled by the operand size, so it can only move the address upward from the base.

The address is registered, and a valid pulse marks it one clock after the request. The same edge also produces a misalignment flag for the access. An illegal size code raises an error flag instead, and the last address is kept.

Top module: `lsu_ea_gen`

## Requirements
- R1: With `mode_i` = 00, the address is `rn_i` + (zero-extended `disp_i[3:0]` × 1, 2 or 4) for `size_i` = 00 (byte), 01 (word) or 10 (longword).
- R2: With `mode_i` = 01, the address is `rn_i` + `idx_i`, with no scaling, and `disp_i` has no effect.
- R3: With `mode_i` = 10, the address is `gbase_i` + (zero-extended `disp_i[7:0]` × 1, 2 or 4) by operand size.
- R4: With `mode_i` = 11, the address is `gbase_i` + `idx_i`, with no scaling.
- R5: The displacement is never sign-extended. A field with its top bit set adds a positive offset (for example 0xF longword adds 60).
- R6: All sums wrap modulo 2^32, and the carry out of bit 31 is dropped.
- R7: A request with a legal size updates `addr_o` and drives `valid_o` high on the next clock edge. In a cycle after no request, `valid_o` is low.
- R8: A request with `size_i` = 11 drives `size_err_o` high and `valid_o` low on the next edge, and leaves `addr_o` unchanged.
- R9: `misalign_o` follows each legal request. It is high for a word address with bit 0 set and for a longword address with either low bit set. It is low for byte accesses and in cycles after no request.
- R10: Synchronous reset clears `valid_o`, `misalign_o` and `size_err_o`, and sets `addr_o` to zero.
- R11: With `mode_i` = 00, bits 7:4 of `disp_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe, one address per asserted cycle |
| mode_i | input | 2 | Addressing form (00 reg+disp4, 01 reg+R0, 10 base+disp8, 11 base+R0) |
| size_i | input | 2 | Operand size (00 byte, 01 word, 10 longword, 11 illegal) |
| disp_i | input | 8 | Displacement field (low 4 bits used by form 00) |
| rn_i | input | 32 | General register operand |
| idx_i | input | 32 | Index register (R0) operand |
| gbase_i | input | 32 | Global base register operand |
| addr_o | output | 32 | Registered effective address |
| valid_o | output | 1 | Address valid, one cycle after a legal request |
| misalign_o | output | 1 | Access not aligned to its operand size |
| size_err_o | output | 1 | Request carried the illegal size code |

## Verification
Some properties are checked on every cycle: the request-to-valid timing, the quiet outputs after an idle cycle, the held address and error pulse for an illegal size, the misalignment flag against the low address bits, and the sums of the indexed and displacement forms. Other behaviours can only be shown by the bench's chosen operands. These include top-bit-set displacements adding upward, the wrap past 2^32, the ignored upper displacement nibble, and reset in the middle of a run clearing a non-zero address.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [1:0] {
        EA_RN_DISP = 2'b00,
        EA_RN_IDX  = 2'b01,
        EA_GB_DISP = 2'b10,
        EA_GB_IDX  = 2'b11
    } ea_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } ea_size_e;

    // log2 of the access width in bytes; the illegal code maps to zero
    function automatic logic [1:0] size_shift(ea_size_e sz);
        case (sz)
            SZ_WORD: return 2'd1;
            SZ_LONG: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/ea_disp_scale.sv
module ea_disp_scale #(
    parameter int FIELD_W = 4,
    parameter int OUT_W   = 32
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic [1:0]         shamt_i,
    output logic [OUT_W-1:0]   offs_o
);
    localparam int PAD_W = OUT_W - FIELD_W;

    logic [OUT_W-1:0] zext;

    // zero extension only: offsets never point below the base
    assign zext   = {{PAD_W{1'b0}}, field_i};
    assign offs_o = zext << shamt_i;
endmodule

// File: rtl/ea_align_chk.sv
module ea_align_chk
    import ea_pkg::*;
(
    input  ea_size_e   size_i,
    input  logic [1:0] low_i,
    output logic       misalign_o
);
    always_comb begin
        case (size_i)
            SZ_WORD: misalign_o = low_i[0];
            SZ_LONG: misalign_o = |low_i;
            default: misalign_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
    import ea_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SHORT_W  = 4,
    parameter int LONG_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic [LONG_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] rn_i,
    input  logic [ADDR_W-1:0] idx_i,
    input  logic [ADDR_W-1:0] gbase_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              misalign_o,
    output logic              size_err_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
        logic              mis;
        logic              err;
    } ea_state_t;

    localparam ea_state_t RST_STATE = '{addr: '0, valid: 1'b0, mis: 1'b0, err: 1'b0};

    ea_mode_e  mode;
    ea_size_e  size;
    logic [1:0] shamt;
    logic [ADDR_W-1:0] short_off;
    logic [ADDR_W-1:0] long_off;
    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] off_sel;
    logic [ADDR_W-1:0] sum;
    logic              mis_w;
    ea_state_t         st_d, st_q;

    assign mode  = ea_mode_e'(mode_i);
    assign size  = ea_size_e'(size_i);
    assign shamt = size_shift(size);

    ea_disp_scale #(.FIELD_W(SHORT_W), .OUT_W(ADDR_W)) u_short (
        .field_i (disp_i[SHORT_W-1:0]),
        .shamt_i (shamt),
        .offs_o  (short_off)
    );

    ea_disp_scale #(.FIELD_W(LONG_W), .OUT_W(ADDR_W)) u_long (
        .field_i (disp_i),
        .shamt_i (shamt),
        .offs_o  (long_off)
    );

    always_comb begin
        case (mode)
            EA_RN_DISP: begin base_sel = rn_i;    off_sel = short_off; end
            EA_RN_IDX:  begin base_sel = rn_i;    off_sel = idx_i;     end
            EA_GB_DISP: begin base_sel = gbase_i; off_sel = long_off;  end
            default:    begin base_sel = gbase_i; off_sel = idx_i;     end
        endcase
    end

    // modulo 2^ADDR_W: carry out of the top bit is discarded
    assign sum = base_sel + off_sel;

    ea_align_chk u_align (
        .size_i     (size),
        .low_i      (sum[1:0]),
        .misalign_o (mis_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.mis   = 1'b0;
        st_d.err   = 1'b0;
        if (req_i) begin
            if (size == SZ_BAD) begin
                st_d.err = 1'b1;
            end else begin
                st_d.addr  = sum;
                st_d.valid = 1'b1;
                st_d.mis   = mis_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RST_STATE;
        else     st_q <= st_d;
    end

    assign addr_o     = st_q.addr;
    assign valid_o    = st_q.valid;
    assign misalign_o = st_q.mis;
    assign size_err_o = st_q.err;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int LONG_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic [1:0]        mode_i,
    input logic [1:0]        size_i,
    input logic [LONG_W-1:0] disp_i,
    input logic [ADDR_W-1:0] rn_i,
    input logic [ADDR_W-1:0] idx_i,
    input logic [ADDR_W-1:0] gbase_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              valid_o,
    input logic              misalign_o,
    input logic              size_err_o
);
    logic legal;
    assign legal = (size_i != 2'b11);

    a_r7_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_i && legal |=> valid_o && !size_err_o);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !valid_o && !misalign_o && !size_err_o);

    a_r8_bad_size_holds: assert property (@(posedge clk) disable iff (rst)
        req_i && !legal |=> size_err_o && !valid_o && $stable(addr_o));

    a_r9_byte_aligned: assert property (@(posedge clk) disable iff (rst)
        req_i && size_i == 2'b00 |=> !misalign_o);

    a_r9_word_align: assert property (@(posedge clk) disable iff (rst)
        req_i && size_i == 2'b01 |=> misalign_o == addr_o[0]);

    a_r9_long_align: assert property (@(posedge clk) disable iff (rst)
        req_i && size_i == 2'b10 |=> misalign_o == (addr_o[1:0] != 2'b00));

    a_r2_rn_index: assert property (@(posedge clk) disable iff (rst)
        req_i && legal && mode_i == 2'b01 |=> addr_o == $past(rn_i) + $past(idx_i));

    a_r4_base_index: assert property (@(posedge clk) disable iff (rst)
        req_i && legal && mode_i == 2'b11 |=> addr_o == $past(gbase_i) + $past(idx_i));

    a_r3_base_byte_disp: assert property (@(posedge clk) disable iff (rst)
        req_i && size_i == 2'b00 && mode_i == 2'b10
        |=> addr_o - $past(gbase_i) == ADDR_W'($past(disp_i)));
endmodule

bind lsu_ea_gen ea_gen_chk #(.ADDR_W(ADDR_W), .LONG_W(LONG_W)) u_ea_gen_chk (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .mode_i     (mode_i),
    .size_i     (size_i),
    .disp_i     (disp_i),
    .rn_i       (rn_i),
    .idx_i      (idx_i),
    .gbase_i    (gbase_i),
    .addr_o     (addr_o),
    .valid_o    (valid_o),
    .misalign_o (misalign_o),
    .size_err_o (size_err_o)
);

// File: tb/test_lsu_ea_gen.sv
module test_lsu_ea_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  size_i = '0;
    logic [7:0]  disp_i = '0;
    logic [31:0] rn_i = '0;
    logic [31:0] idx_i = '0;
    logic [31:0] gbase_i = '0;
    logic [31:0] addr_o;
    logic        valid_o, misalign_o, size_err_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_addr = '0;
    bit finished = 0;

    typedef struct {
        logic [31:0] addr;
        logic        valid;
        logic        mis;
        logic        err;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_ea_gen i_lsu_ea_gen (
        .clk(clk), .rst(rst), .req_i(req_i), .mode_i(mode_i), .size_i(size_i),
        .disp_i(disp_i), .rn_i(rn_i), .idx_i(idx_i), .gbase_i(gbase_i),
        .addr_o(addr_o), .valid_o(valid_o), .misalign_o(misalign_o),
        .size_err_o(size_err_o)
    );

    function automatic logic [31:0] ref_addr(logic [1:0] m, logic [1:0] s, logic [7:0] d,
                                             logic [31:0] rn, logic [31:0] ix, logic [31:0] gb);
        logic [31:0] mult;
        mult = (s == 2'b00) ? 32'd1 : (s == 2'b01) ? 32'd2 : 32'd4;
        case (m)
            2'b00:   return rn + {28'd0, d[3:0]} * mult;
            2'b01:   return rn + ix;
            2'b10:   return gb + {24'd0, d} * mult;
            default: return gb + ix;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] ea, logic ev, logic em, logic ee);
        checks++;
        if (addr_o !== ea || valid_o !== ev || misalign_o !== em || size_err_o !== ee) begin
            errors++;
            $display("FAIL %s: got addr=%h v=%b mis=%b err=%b, expected addr=%h v=%b mis=%b err=%b",
                     tag, addr_o, valid_o, misalign_o, size_err_o, ea, ev, em, ee);
        end
    endtask

    task automatic issue(logic [1:0] m, logic [1:0] s, logic [7:0] d,
                         logic [31:0] rn, logic [31:0] ix, logic [31:0] gb, string tag);
        exp_t e;
        logic [31:0] a;
        @(negedge clk);
        mode_i = m; size_i = s; disp_i = d; rn_i = rn; idx_i = ix; gbase_i = gb;
        req_i = 1'b1;
        e.tag = tag;
        if (s == 2'b11) begin
            e.addr = model_addr; e.valid = 1'b0; e.mis = 1'b0; e.err = 1'b1;
        end else begin
            a = ref_addr(m, s, d, rn, ix, gb);
            model_addr = a;
            e.addr = a; e.valid = 1'b1; e.err = 1'b0;
            e.mis = (s == 2'b01) ? a[0] : (s == 2'b10) ? (a[1:0] != 2'b00) : 1'b0;
        end
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_i = 1'b0;
    endtask

    // monitor: compares each result one edge after its request
    always @(posedge clk) begin
        #1;
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, e.addr, e.valid, e.mis, e.err);
        end else if (!rst && !finished) begin
            checks++;
            if (valid_o !== 1'b0 || size_err_o !== 1'b0 || misalign_o !== 1'b0) begin
                errors++;
                $display("FAIL R7 idle: got v=%b mis=%b err=%b, expected 0 0 0",
                         valid_o, misalign_o, size_err_o);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset state", 32'h0, 1'b0, 1'b0, 1'b0);

        issue(2'b00, 2'b00, 8'h0F, 32'h0000_1000, 32'h0, 32'h0, "R1 R5 rn+disp byte");
        issue(2'b00, 2'b01, 8'hFA, 32'h0000_1000, 32'h0, 32'h0, "R11 R1 rn+disp word upper nibble");
        issue(2'b00, 2'b01, 8'h03, 32'h0000_1001, 32'h0, 32'h0, "R9 word odd address");
        issue(2'b00, 2'b10, 8'h0F, 32'h0000_2000, 32'h0, 32'h0, "R5 R1 rn+disp long 0xF");
        issue(2'b01, 2'b10, 8'hFF, 32'h0000_3000, 32'h123, 32'h0, "R2 R9 rn+idx long misaligned");
        issue(2'b01, 2'b00, 8'h55, 32'h0000_0010, 32'h4, 32'h0, "R2 rn+idx byte");
        idle();
        idle();
        issue(2'b10, 2'b00, 8'hFF, 32'h0, 32'h0, 32'h8000_0000, "R3 R5 base+disp byte");
        issue(2'b10, 2'b01, 8'hFF, 32'h0, 32'h0, 32'h8000_0000, "R3 base+disp word");
        issue(2'b10, 2'b10, 8'hFF, 32'h0, 32'h0, 32'h8000_0000, "R3 base+disp long");
        issue(2'b11, 2'b01, 8'h00, 32'h0, 32'h0000_0011, 32'h4000_0000, "R4 R9 base+idx word odd");
        issue(2'b11, 2'b10, 8'h00, 32'h0, 32'h0000_0008, 32'h4000_0000, "R4 base+idx long aligned");
        issue(2'b01, 2'b00, 8'h00, 32'hFFFF_FFF0, 32'h20, 32'h0, "R6 wrap rn+idx");
        issue(2'b10, 2'b10, 8'h01, 32'h0, 32'h0, 32'hFFFF_FFFF, "R6 R9 wrap base+disp long");
        issue(2'b00, 2'b11, 8'h04, 32'h1234_0000, 32'h0, 32'h0, "R8 illegal size holds addr");
        idle();
        issue(2'b11, 2'b11, 8'h00, 32'h0, 32'h50, 32'h5000, "R8 illegal size again");
        issue(2'b00, 2'b10, 8'h01, 32'h0000_0002, 32'h0, 32'h0, "R9 R7 legal after illegal");
        idle();
        idle();

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 mid-run reset clears", 32'h0, 1'b0, 1'b0, 1'b0);
        model_addr = 32'h0;
        issue(2'b01, 2'b11, 8'h00, 32'h77, 32'h1, 32'h0, "R8 R10 illegal after reset keeps zero");
        idle();
        idle();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule